// File: doc/BRIEF.md
# LPC Memory-Write Target Engine

This block sits on the peripheral side of a Low Pin Count bus and accepts memory-write cycles from the host. It watches the frame strobe and the 4-bit multiplexed nibble bus. It recognises a start and a memory-write cycle type, and gathers a 32-bit address and one data byte. It waits through the host turnaround, answers with a ready sync nibble and hands the bus back. For every claimed cycle it then presents the decoded byte write on a one-clock strobe together with the address and the data.

The target claims a cycle only when its address falls in one of two fixed windows: the top 4 MB of the 32-bit space, or the 128 KB region just below the 1 MB boundary. Outside those windows the engine stays silent and never drives the bus. A frame strobe reasserted mid-cycle, or a synchronous reset, abandons the cycle at once. The bidirectional bus is split into an input nibble, an output nibble and an output enable. The pad logic around the block joins them.

Clock numbering in the requirements counts the clock that carries the start nibble (frame low) as clock 0. Outputs are named by the clock in which they are valid.

Top module: `lpc_mwr_target`

## Requirements
- R1: After a clock edge with rst_n low, nib_oe, wr_stb and addr_hit are all 0.
- R2: A cycle starts on a clock where frame_n is low and nib_in is 0000b. If frame_n stays low with 0000b for several clocks, the last of them is clock 0.
- R3: The clock 1 nibble is the cycle type. Only values with bits [3:1] = 011b (6h or 7h) are memory writes. Any other type is ignored: no drive, no hit, no strobe until the next start.
- R4: Clocks 2 to 9 carry the address most significant nibble first (clock 2 = A[31:28], clock 9 = A[3:0]). wr_addr shows that address during the strobe.
- R5: Clocks 10 and 11 carry the data low nibble first (clock 10 = D[3:0], clock 11 = D[7:4]). wr_data shows that byte during the strobe.
- R6: A cycle is claimed when the address is in FFC00000h..FFFFFFFFh or in 000E0000h..000FFFFFh. addr_hit is 1 in clocks 10 through 15 of a claimed cycle and 0 otherwise.
- R7: For an address outside both windows, nib_oe stays 0 and wr_stb stays 0 until the next start.
- R8: In a claimed cycle the target leaves the bus to the host in clocks 12 and 13. It drives 0000b (ready) in clock 14 and 1111b in clock 15, and releases the bus (nib_oe = 0) from clock 16.
- R9: wr_stb is 1 for exactly one clock, clock 15 of a claimed cycle, right after the sync clock.
- R10: frame_n low in clock k (2 <= k) with a non-start nibble abandons the cycle. From clock k+1, nib_oe, addr_hit and wr_stb stay 0 until the next start.
- R11: rst_n low in clock k of a cycle abandons it. From clock k+1 the engine is idle and ignores the remaining nibbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Cycle frame strobe from the host, active low |
| nib_in | input | 4 | Nibble bus as seen at the pad |
| nib_out | output | 4 | Nibble driven by the target |
| nib_oe | output | 1 | Output enable for nib_out |
| wr_stb | output | 1 | One-clock byte write strobe |
| wr_addr | output | 32 | Address of the write |
| wr_data | output | 8 | Byte of the write |
| addr_hit | output | 1 | Current cycle is claimed |

## Verification
Two decisions can meet in the same clock. One is the window decision taken on the last address nibble. The other is an abort by a reasserted frame strobe or by reset. When they meet, the abort must win: the cycle is not claimed. The bench places aborts at random clocks from 2 to 13, including clock 9. It mixes them with random and boundary addresses such as FFBFFFFFh, FFC00000h, 000DFFFFh and 00100000h. A reference function marks each clock as still live or already abandoned. addr_hit, the drive enable and the strobe are compared against that marking in every clock of every transaction.

// File: rtl/lpc_mwr_pkg.sv
// Package: shared phase encoding and bus constants for the LPC memory-write
// target. Assumes a 4-bit nibble bus.
package lpc_mwr_pkg;

    localparam int NIB_W = 4;

    // Bus phase of the current clock, named by what the nibble carries.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_TYPE  = 3'd1,
        PH_ADDR  = 3'd2,
        PH_DATA  = 3'd3,
        PH_HTAR  = 3'd4,
        PH_FLOAT = 3'd5,
        PH_SYNC  = 3'd6,
        PH_RTAR  = 3'd7
    } phase_t;

    localparam logic [NIB_W-1:0] NIB_START = 4'h0;
    localparam logic [NIB_W-1:0] NIB_READY = 4'h0;
    localparam logic [NIB_W-1:0] NIB_PARK  = 4'hF;
    localparam logic [2:0]       TYPE_MWR  = 3'b011;

endpackage

// File: rtl/lpc_mwr_win_dec.sv
// Module: address window decoder. Reports whether an address matches any of
// NUM_WIN base/mask pairs. Assumes each window is aligned to its size, so a
// masked compare is enough.
module lpc_mwr_win_dec #(
    parameter int                          ADDR_W   = 32,
    parameter int                          NUM_WIN  = 2,
    parameter logic [NUM_WIN*ADDR_W-1:0]   WIN_BASE = '0,
    parameter logic [NUM_WIN*ADDR_W-1:0]   WIN_MASK = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic [NUM_WIN-1:0] match;

    // One comparator per window.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign match[w] = ((addr & WIN_MASK[w*ADDR_W +: ADDR_W]) ==
                           WIN_BASE[w*ADDR_W +: ADDR_W]);
    end

    assign hit = |match;

endmodule

// File: rtl/lpc_mwr_collect.sv
// Module: nibble collector. Shifts address nibbles in most significant first
// and places data nibbles into the slot given by the sequencer, lowest slot
// first. Also offers the address as it will be after the current nibble, so
// that the window decision can be made on the last address clock.
module lpc_mwr_collect #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    localparam int NIB_W     = lpc_mwr_pkg::NIB_W,
    localparam int DATA_NIBS = DATA_W / NIB_W,
    localparam int DIDX_W    = $clog2(DATA_NIBS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  nib,
    input  logic              addr_en,
    input  logic              data_en,
    input  logic [DIDX_W-1:0] data_idx,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] addr_next,
    output logic [DATA_W-1:0] data_q
);

    assign addr_next = {addr_q[ADDR_W-NIB_W-1:0], nib};

    // Address shift register, loaded one nibble per address clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_en) begin
            addr_q <= addr_next;
        end
    end

    // Data register, one nibble slot per data clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (data_en) begin
            data_q[data_idx*NIB_W +: NIB_W] <= nib;
        end
    end

endmodule

// File: rtl/lpc_mwr_seq.sv
// Module: cycle sequencer. Tracks the bus phase of a memory-write cycle,
// counts address and data nibbles, keeps the claim flag and produces the
// target drive and the write strobe. Assumes ADDR_NIBS >= DATA_NIBS >= 2.
// A low frame strobe in any clock overrides the phase: with a start nibble
// it begins a new cycle, otherwise it returns to idle.
module lpc_mwr_seq #(
    parameter int ADDR_NIBS = 8,
    parameter int DATA_NIBS = 2,
    localparam int NIB_W  = lpc_mwr_pkg::NIB_W,
    localparam int CNT_W  = $clog2(ADDR_NIBS),
    localparam int DIDX_W = $clog2(DATA_NIBS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [NIB_W-1:0]  nib,
    input  logic              win_hit,
    output logic              addr_en,
    output logic              data_en,
    output logic [DIDX_W-1:0] data_idx,
    output logic              claim,
    output logic              drive_en,
    output logic [NIB_W-1:0]  drive_nib,
    output logic              stb
);
    import lpc_mwr_pkg::*;

    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);

    phase_t           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             claim_q, claim_d;

    // Next phase, nibble count and claim flag.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        claim_d = claim_q;
        if (!frame_n) begin
            claim_d = 1'b0;
            cnt_d   = '0;
            phase_d = (nib == NIB_START) ? PH_TYPE : PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:  phase_d = PH_IDLE;
                PH_TYPE: begin
                    cnt_d   = '0;
                    phase_d = (nib[3:1] == TYPE_MWR) ? PH_ADDR : PH_IDLE;
                end
                PH_ADDR: begin
                    if (cnt_q == ADDR_LAST) begin
                        cnt_d   = '0;
                        claim_d = win_hit;
                        phase_d = win_hit ? PH_DATA : PH_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (cnt_q == DATA_LAST) begin
                        cnt_d   = '0;
                        phase_d = PH_HTAR;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_HTAR:  phase_d = PH_FLOAT;
                PH_FLOAT: phase_d = PH_SYNC;
                PH_SYNC:  phase_d = PH_RTAR;
                PH_RTAR: begin
                    claim_d = 1'b0;
                    phase_d = PH_IDLE;
                end
                default:  phase_d = PH_IDLE;
            endcase
        end
    end

    // Phase, count and claim registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            claim_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            claim_q <= claim_d;
        end
    end

    // Collector enables follow the phase while the frame strobe is high.
    assign addr_en  = frame_n && (phase_q == PH_ADDR);
    assign data_en  = frame_n && (phase_q == PH_DATA);
    assign data_idx = cnt_q[DIDX_W-1:0];

    // Target drive: ready nibble in sync, park nibble in the final turnaround.
    assign drive_en  = claim_q && ((phase_q == PH_SYNC) || (phase_q == PH_RTAR));
    assign drive_nib = (phase_q == PH_SYNC) ? NIB_READY : NIB_PARK;
    assign stb       = claim_q && (phase_q == PH_RTAR);
    assign claim     = claim_q;

endmodule

// File: rtl/lpc_mwr_target.sv
// Module: LPC memory-write target, top level. Accepts host memory-write
// cycles, claims those whose address falls in one of the decoded windows,
// answers with a ready sync and emits a one-clock byte write. Assumes the
// pad logic merges nib_out/nib_oe onto the shared bus and feeds the pad value
// back on nib_in.
module lpc_mwr_target #(
    parameter int                  ADDR_W    = 32,
    parameter int                  DATA_W    = 8,
    parameter logic [ADDR_W-1:0]   HI_BASE   = 32'hFFC0_0000,
    parameter logic [ADDR_W-1:0]   HI_MASK   = 32'hFFC0_0000,
    parameter logic [ADDR_W-1:0]   LO_BASE   = 32'h000E_0000,
    parameter logic [ADDR_W-1:0]   LO_MASK   = 32'hFFFE_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [3:0]        nib_in,
    output logic [3:0]        nib_out,
    output logic              nib_oe,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              addr_hit
);

    localparam int NIB_W     = lpc_mwr_pkg::NIB_W;
    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int DATA_NIBS = DATA_W / NIB_W;
    localparam int DIDX_W    = $clog2(DATA_NIBS);

    logic              addr_en;
    logic              data_en;
    logic [DIDX_W-1:0] data_idx;
    logic [ADDR_W-1:0] addr_next;
    logic              win_hit;

    lpc_mwr_seq #(
        .ADDR_NIBS (ADDR_NIBS),
        .DATA_NIBS (DATA_NIBS)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .nib       (nib_in),
        .win_hit   (win_hit),
        .addr_en   (addr_en),
        .data_en   (data_en),
        .data_idx  (data_idx),
        .claim     (addr_hit),
        .drive_en  (nib_oe),
        .drive_nib (nib_out),
        .stb       (wr_stb)
    );

    lpc_mwr_collect #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) collect_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib       (nib_in),
        .addr_en   (addr_en),
        .data_en   (data_en),
        .data_idx  (data_idx),
        .addr_q    (wr_addr),
        .addr_next (addr_next),
        .data_q    (wr_data)
    );

    lpc_mwr_win_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_WIN  (2),
        .WIN_BASE ({HI_BASE, LO_BASE}),
        .WIN_MASK ({HI_MASK, LO_MASK})
    ) dec_i (
        .addr (addr_next),
        .hit  (win_hit)
    );

endmodule

// File: rtl/lpc_mwr_chk.sv
// Module: protocol checker for lpc_mwr_target, attached with bind. Observes
// the ports only.
module lpc_mwr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_n,
    input logic [3:0]  nib_in,
    input logic [3:0]  nib_out,
    input logic        nib_oe,
    input logic        wr_stb,
    input logic [31:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic        addr_hit
);

    // R7: the target drives only in a claimed cycle.
    assert_drive_needs_claim_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nib_oe |-> addr_hit);

    // R6: a claim starts only for an address inside a window.
    assert_claim_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_hit) |-> ((wr_addr >= 32'hFFC0_0000) ||
                             ((wr_addr >= 32'h000E_0000) && (wr_addr <= 32'h000F_FFFF))));

    // R8: the strobe clock parks 1111b after a ready clock of 0000b.
    assert_sync_then_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (nib_oe && (nib_out == 4'hF) && $past(nib_oe) && ($past(nib_out) == 4'h0)));

    // R9: the strobe is a single clock wide.
    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R9: address and data are settled while the strobe is high.
    assert_fields_settled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($stable(wr_addr) && $stable(wr_data)));

    // R10: a frame strobe with a non-start nibble drops the claim and the drive.
    assert_abort_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && (nib_in != 4'h0)) |=> (!nib_oe && !addr_hit && !wr_stb));

endmodule

bind lpc_mwr_target lpc_mwr_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .nib_in   (nib_in),
    .nib_out  (nib_out),
    .nib_oe   (nib_oe),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .addr_hit (addr_hit)
);

// File: tb/lpc_mwr_target_tb_top.sv
`timescale 1ns/1ps
// Bench: drives host memory-write cycles on negative edges, checks the target
// outputs at every negative edge against values computed from the requirements.
module lpc_mwr_target_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_n;
    logic [3:0]  host_nib;
    logic        host_drv;
    logic [3:0]  nib_in;
    logic [3:0]  nib_out;
    logic        nib_oe;
    logic        wr_stb;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;
    logic        addr_hit;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    // Shared bus with a pull-up when nobody drives.
    assign nib_in = nib_oe ? nib_out : (host_drv ? host_nib : 4'hF);

    lpc_mwr_target dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .nib_in   (nib_in),
        .nib_out  (nib_out),
        .nib_oe   (nib_oe),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .addr_hit (addr_hit)
    );

    function automatic bit in_window(input logic [31:0] a);
        return (a >= 32'hFFC0_0000) || ((a >= 32'h000E_0000) && (a <= 32'h000F_FFFF));
    endfunction

    function automatic bit is_mwr(input logic [3:0] t);
        return (t == 4'h6) || (t == 4'h7);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One host transaction. abort_at < 0: none; kind 0 = frame abort, 1 = reset.
    task automatic do_write(input logic [31:0] a, input logic [7:0] d,
                            input logic [3:0] typ, input int abort_at,
                            input int kind, input int start_len, input string tg);
        for (int p = 1; p < start_len; p++) begin
            @(negedge clk);
            chk({tg, " R2"}, "nib_oe in extra start", 32'(nib_oe), 32'd0);
            frame_n = 1'b0; host_drv = 1'b1; host_nib = 4'h0;
        end
        for (int s = 0; s <= 17; s++) begin
            bit live, hit_e, oe_e, stb_e;
            @(negedge clk);
            live  = (abort_at < 0) || (s <= abort_at);
            hit_e = is_mwr(typ) && in_window(a) && live && (s >= 10) && (s <= 15);
            oe_e  = hit_e && (s == 14 || s == 15);
            stb_e = hit_e && (s == 15);
            chk({tg, " R6"}, "addr_hit", 32'(addr_hit), 32'(hit_e));
            chk({tg, " R8"}, "nib_oe", 32'(nib_oe), 32'(oe_e));
            if (oe_e)
                chk({tg, " R8"}, "nib_out", 32'(nib_out), (s == 14) ? 32'h0 : 32'hF);
            chk({tg, " R9"}, "wr_stb", 32'(wr_stb), 32'(stb_e));
            if (stb_e) begin
                chk({tg, " R4"}, "wr_addr", wr_addr, a);
                chk({tg, " R5"}, "wr_data", 32'(wr_data), 32'(d));
            end
            rst_n    = 1'b1;
            frame_n  = 1'b1;
            host_drv = 1'b0;
            host_nib = 4'hF;
            if (s >= 0 && s <= 12) host_drv = 1'b1;
            case (s)
                0:       begin frame_n = 1'b0; host_nib = 4'h0; end
                1:       host_nib = typ;
                10:      host_nib = d[3:0];
                11:      host_nib = d[7:4];
                12:      host_nib = 4'hF;
                default: if (s >= 2 && s <= 9) host_nib = a[31-4*(s-2) -: 4];
            endcase
            if (s == abort_at) begin
                if (kind == 0) begin
                    frame_n  = 1'b0;
                    host_drv = 1'b1;
                    host_nib = 4'h5;
                end else begin
                    rst_n = 1'b0;
                end
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] edges [8];
        void'($urandom(32'h5EED_1234));
        edges[0] = 32'hFFC0_0000; edges[1] = 32'hFFFF_FFFF;
        edges[2] = 32'hFFBF_FFFF; edges[3] = 32'h000E_0000;
        edges[4] = 32'h000F_FFFF; edges[5] = 32'h000D_FFFF;
        edges[6] = 32'h0010_0000; edges[7] = 32'h0000_5555;

        rst_n = 1'b0; frame_n = 1'b1; host_drv = 1'b0; host_nib = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "nib_oe after reset", 32'(nib_oe), 32'd0);
        chk("R1", "wr_stb after reset", 32'(wr_stb), 32'd0);
        chk("R1", "addr_hit after reset", 32'(addr_hit), 32'd0);
        rst_n = 1'b1;

        // Directed boundary and mode cases.
        for (int i = 0; i < 8; i++)
            do_write(edges[i], 8'(8'hA5 ^ i), 4'h6, -1, 0, 1,
                     in_window(edges[i]) ? "R6" : "R7");
        do_write(32'hFFC0_1234, 8'h3C, 4'h7, -1, 0, 2, "R2");
        do_write(32'h000E_5555, 8'hC3, 4'h4, -1, 0, 1, "R3");
        do_write(32'hFFFF_0000, 8'h5A, 4'h2, -1, 0, 1, "R3");
        do_write(32'hFFF0_5555, 8'hAA, 4'h6, 9, 0, 1, "R10");
        do_write(32'hFFF0_2AAA, 8'h55, 4'h6, 13, 0, 1, "R10");
        do_write(32'h000F_5555, 8'hA0, 4'h6, 9, 1, 1, "R11");
        do_write(32'h000F_0001, 8'h0F, 4'h6, 12, 1, 1, "R11");
        do_write(32'hFFC0_0001, 8'hF0, 4'h6, -1, 0, 1, "R5");

        // Constrained random traffic.
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a;
            logic [3:0]  t;
            int          ab, kd, sl;
            case ($urandom_range(0, 3))
                0:       a = {10'h3FF, 22'($urandom)};
                1:       a = {15'h0007, 17'($urandom)};
                2:       a = $urandom;
                default: a = edges[$urandom_range(0, 7)];
            endcase
            t  = ($urandom_range(0, 7) == 0) ? 4'($urandom) : ($urandom_range(0, 1) ? 4'h6 : 4'h7);
            ab = ($urandom_range(0, 5) == 0) ? int'($urandom_range(2, 13)) : -1;
            kd = int'($urandom_range(0, 1));
            sl = int'($urandom_range(1, 2));
            do_write(a, 8'($urandom), t, ab, kd, sl,
                     (ab >= 0) ? ((kd == 0) ? "R10" : "R11") : "R4");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule